// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Pipeline

This block chooses where the execute-stage operands and the memory-stage store data come from in a five-stage in-order pipeline. Each cycle it compares the destination register numbers held in the two later pipeline latches (execute/memory and memory/writeback) with the two source registers of the instruction now in execute. When one of them matches, it steers the newer latched result to the ALU input in place of the stale register-file value.

It adds a third path for store data. A store in the memory stage can take its data word straight from the memory/writeback latch. Because of this, a load followed at once by a store of the loaded register needs no stall.

The select logic is purely combinational. The module also holds the three operand muxes, so the chosen data words can be checked end to end. Stall generation, the register file and the ALU sit outside this block.

Top module: `bypass_select`

## Requirements
- R1: When neither latch supplies a source register, its select is 2'b00 and the operand equals the register-file word for that input.
- R2: When the execute/memory latch writes a nonzero destination equal to a source register, that input's select is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/writeback latch writes a nonzero destination equal to a source register, that input's select is 2'b01 and the operand equals the memory/writeback result.
- R4: When both latches write the same nonzero register and it matches a source, the execute/memory latch wins (select 2'b10).
- R5: Register 0 is never a bypass source. A source or destination of 0 gives select 2'b00, and store-data select 0.
- R6: A latch whose write-enable flag is 0 never supplies a bypass value, even when its destination number matches.
- R7: When the memory-stage instruction is a store, its Rt is nonzero, the memory/writeback latch writes that register, and that latch's write enable is 1, the store-data select is 1 and the store data equals the memory/writeback result. Otherwise the select is 0 and the store data is the word carried in the pipeline.
- R8: A memory-stage instruction whose store flag is 0 never sets the store-data select, even if its Rt matches.
- R9: The two ALU inputs are selected independently; each may take a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xm_dst | input | 5 | Destination register in the execute/memory latch |
| xm_wen | input | 1 | Register-write flag of the execute/memory latch |
| xm_val | input | DW | Result word in the execute/memory latch |
| mw_dst | input | 5 | Destination register in the memory/writeback latch |
| mw_wen | input | 1 | Register-write flag of the memory/writeback latch |
| mw_val | input | DW | Result word in the memory/writeback latch |
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute |
| rf_a | input | DW | Register-file word read for the first source |
| rf_b | input | DW | Register-file word read for the second source |
| mem_rt | input | 5 | Rt field of the instruction in the memory stage |
| mem_st | input | 1 | Store flag of the instruction in the memory stage |
| mem_sd | input | DW | Store data carried in the pipeline latch |
| sel_a | output | 2 | Select for ALU input A (00 file, 10 exec/mem, 01 mem/wb) |
| sel_b | output | 2 | Select for ALU input B (same encoding) |
| sel_st | output | 1 | Store-data select (1 = memory/writeback result) |
| op_a | output | DW | Chosen ALU operand A |
| op_b | output | DW | Chosen ALU operand B |
| st_data | output | DW | Chosen store data |

## Verification
The vector table covers several input patterns, and each one separates a different pair of behaviours:
- A plain ALU-to-ALU dependence against independent operands shows that the execute/memory path fires only on a real match.
- A two-slot dependence shows the memory/writeback path.
- A register matched in both latches separates correct priority from the reverse.
- Vectors with the register-write flag cleared, or with register 0 as source and destination, show that a bypass is never taken from a latch that writes nothing.
- Store vectors vary the store flag, the Rt match and the producer's write flag, so that the store-data bypass is seen both taken and refused.
- One vector gives the two ALU inputs different sources at once.

Each select is checked against the data word on the matching output.

// File: rtl/bypass_select.sv
module bypass_select #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] xm_dst,
  input  logic          xm_wen,
  input  logic [DW-1:0] xm_val,
  input  logic [RW-1:0] mw_dst,
  input  logic          mw_wen,
  input  logic [DW-1:0] mw_val,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [RW-1:0] mem_rt,
  input  logic          mem_st,
  input  logic [DW-1:0] mem_sd,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          sel_st,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [DW-1:0] st_data
);

  localparam logic [1:0] SRC_RF = 2'b00;
  localparam logic [1:0] SRC_XM = 2'b10;
  localparam logic [1:0] SRC_MW = 2'b01;

  logic xm_live, mw_live;
  assign xm_live = xm_wen && (xm_dst != '0);
  assign mw_live = mw_wen && (mw_dst != '0);

  function automatic logic [1:0] pick(input logic [RW-1:0] src);
    if (xm_live && xm_dst == src)      pick = SRC_XM;
    else if (mw_live && mw_dst == src) pick = SRC_MW;
    else                               pick = SRC_RF;
  endfunction

  assign sel_a  = pick(ex_rs);
  assign sel_b  = pick(ex_rt);
  assign sel_st = mem_st && mw_live && (mw_dst == mem_rt);

  always_comb begin
    case (sel_a)
      SRC_XM:  op_a = xm_val;
      SRC_MW:  op_a = mw_val;
      default: op_a = rf_a;
    endcase
    case (sel_b)
      SRC_XM:  op_b = xm_val;
      SRC_MW:  op_b = mw_val;
      default: op_b = rf_b;
    endcase
  end

  assign st_data = sel_st ? mw_val : mem_sd;

  always_comb begin
    assert_sel_code_R1: assert (sel_a != 2'b11 && sel_b != 2'b11);
    assert_zero_src_R5: assert (!(ex_rs == '0 && sel_a != SRC_RF));
    assert_idle_latch_R6: assert (xm_wen || mw_wen || (sel_a == SRC_RF && sel_b == SRC_RF && !sel_st));
    assert_xm_data_R2: assert (sel_a != SRC_XM || op_a == xm_val);
    assert_mw_data_R3: assert (sel_b != SRC_MW || op_b == mw_val);
    assert_store_flag_R8: assert (mem_st || !sel_st);
    assert_store_data_R7: assert (!sel_st || st_data == mw_val);
  end

endmodule

// File: tb/sim_bypass_select.sv
module sim_bypass_select;
  localparam int DW = 32;
  localparam logic [DW-1:0] XMV = 32'hAAAA0001;
  localparam logic [DW-1:0] MWV = 32'hBBBB0002;
  localparam logic [DW-1:0] RFA = 32'h11110003;
  localparam logic [DW-1:0] RFB = 32'h22220004;
  localparam logic [DW-1:0] SDV = 32'h33330005;

  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic [4:0] xm_dst, mw_dst, ex_rs, ex_rt, mem_rt;
  logic xm_wen, mw_wen, mem_st;
  logic [1:0] sel_a, sel_b;
  logic sel_st;
  logic [DW-1:0] op_a, op_b, st_data;
  int errs = 0, checks = 0;

  bypass_select #(.DW(DW), .RW(5)) u0 (
    .xm_dst(xm_dst), .xm_wen(xm_wen), .xm_val(XMV),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_val(MWV),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .rf_a(RFA), .rf_b(RFB),
    .mem_rt(mem_rt), .mem_st(mem_st), .mem_sd(SDV),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st),
    .op_a(op_a), .op_b(op_b), .st_data(st_data));

  // {xm_dst, xm_wen, mw_dst, mw_wen, ex_rs, ex_rt, mem_rt, mem_st, exp_a, exp_b, exp_st}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {5'd2, 1'b1, 5'd3, 1'b1, 5'd4, 5'd5, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0},    // R1
    {5'd2, 1'b1, 5'd3, 1'b1, 5'd2, 5'd6, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0},    // R2
    {5'd2, 1'b1, 5'd3, 1'b1, 5'd7, 5'd3, 5'd0, 1'b0, 2'b00, 2'b01, 1'b0},    // R3
    {5'd4, 1'b1, 5'd4, 1'b1, 5'd4, 5'd4, 5'd0, 1'b0, 2'b10, 2'b10, 1'b0},    // R4
    {5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0},    // R5
    {5'd8, 1'b0, 5'd8, 1'b1, 5'd8, 5'd9, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0},    // R6
    {5'd8, 1'b0, 5'd9, 1'b0, 5'd8, 5'd9, 5'd9, 1'b1, 2'b00, 2'b00, 1'b0},    // R6
    {5'd1, 1'b1, 5'd10, 1'b1, 5'd11, 5'd12, 5'd10, 1'b1, 2'b00, 2'b00, 1'b1}, // R7
    {5'd1, 1'b1, 5'd10, 1'b1, 5'd11, 5'd12, 5'd10, 1'b0, 2'b00, 2'b00, 1'b0}, // R8
    {5'd1, 1'b1, 5'd10, 1'b1, 5'd11, 5'd12, 5'd11, 1'b1, 2'b00, 2'b00, 1'b0}, // R7
    {5'd1, 1'b1, 5'd10, 1'b0, 5'd11, 5'd12, 5'd10, 1'b1, 2'b00, 2'b00, 1'b0}, // R7
    {5'd13, 1'b1, 5'd14, 1'b1, 5'd14, 5'd13, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0}  // R9
  };

  function automatic logic [DW-1:0] val_of(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      2'b10:   val_of = XMV;
      2'b01:   val_of = MWV;
      default: val_of = rf;
    endcase
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [32:0] v);
    {xm_dst, xm_wen, mw_dst, mw_wen, ex_rs, ex_rt, mem_rt, mem_st} = v[32:5];
  endtask

  initial begin
    drive('0);
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk("R1 reset sel_a", {30'd0, sel_a}, 0);
    chk("R1 reset op_a", op_a, RFA);
    chk("R7 reset st_data", st_data, SDV);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      chk($sformatf("vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i][4:3]});
      chk($sformatf("vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i][2:1]});
      chk($sformatf("vec%0d sel_st", i), {31'd0, sel_st}, {31'd0, VEC[i][0]});
      chk($sformatf("vec%0d op_a", i), op_a, val_of(VEC[i][4:3], RFA));
      chk($sformatf("vec%0d op_b", i), op_b, val_of(VEC[i][2:1], RFB));
      chk($sformatf("vec%0d st_data", i), st_data, VEC[i][0] ? MWV : SDV);
    end

    // R5: register 0 store data never bypassed
    @(negedge clk);
    xm_dst = 5'd0; xm_wen = 1; mw_dst = 5'd0; mw_wen = 1;
    ex_rs = 5'd0; ex_rt = 5'd1; mem_rt = 5'd0; mem_st = 1;
    #1;
    chk("R5 zero rs", {30'd0, sel_a}, 0);
    chk("R5 zero store", {31'd0, sel_st}, 0);
    chk("R5 zero store data", st_data, SDV);

    // R4: priority on second input with exec/mem, first from mem/wb differs
    @(negedge clk);
    xm_dst = 5'd31; xm_wen = 1; mw_dst = 5'd31; mw_wen = 1;
    ex_rs = 5'd30; ex_rt = 5'd31; mem_rt = 5'd31; mem_st = 1;
    #1;
    chk("R4 priority op_b", op_b, XMV);
    chk("R7 store from mw", st_data, MWV);
    chk("R1 no match op_a", op_a, RFA);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule